// File: doc/BRIEF.md
# Repeated String Operation Engine

The engine carries out one block string operation at a time between a byte-wide synchronous memory and a small register set: a source index, a destination index, a count, an accumulator, a source segment base, an extra segment base, a direction flag and a zero flag. Five operations are available: move, compare, scan, load and store. Each can work on bytes or on two-byte words. Each runs either once or under one of three repeat prefixes: unconditional, repeat-while-equal or repeat-while-not-equal. The surrounding core loads the register values and pulses `start`. When `done` pulses, it reads back the updated registers.

The controller is a state machine with eight named states:
- `ST_IDLE` waits for `start`.
- `ST_SRC_RQ` and `ST_SRC_CAP` request one source byte and then capture it.
- `ST_DST_RQ` and `ST_DST_CAP` do the same for a destination byte.
- `ST_WRITE` writes one byte.
- `ST_STEP` updates the indices, the count, the zero flag and the accumulator, and decides whether to repeat.
- `ST_DONE` reports completion.

Transitions:
- idle→first access state of the operation (move, compare and load start at `ST_SRC_RQ`, scan at `ST_DST_RQ`, store at `ST_WRITE`).
- idle→done for a repeat with a zero count.
- request→capture.
- capture→request while bytes of the element remain.
- source capture→write (move), →destination request (compare), or →step (load).
- destination capture→step.
- write→write while bytes remain, then →step.
- step→first access state (repeat) or →done.
- done→idle.

Top module: `str_op_engine`

## Requirements
- R1: `start` is accepted in the idle state only. `busy` is high from the next cycle until the operation ends. `done` is high for exactly one cycle, and while it is high, `si_out`, `di_out`, `cx_out`, `acc_out` and `zf_out` hold the final values.
- R2: The byte address is (segment × 16 + offset) truncated to 20 bits. For the second byte of a word, the offset is incremented modulo 2^16 before the segment is added.
- R3: Words are little-endian. The low byte is at the element's offset and the high byte at offset+1. Both byte reads and byte writes of a word go low byte first.
- R4: After each element, every index the operation uses moves by 1 (byte) or 2 (word). It moves up when the direction flag is 0 and down when it is 1, modulo 2^16. Indices the operation does not use are unchanged.
- R5: Move (op code 0) copies the element at source segment:si to extra segment:di and advances both indices.
- R6: Load (op code 3) reads the element at source segment:si into the accumulator and advances si. A byte load replaces only bits 7:0 of the accumulator.
- R7: Store (op code 4) writes the accumulator element (bits 7:0 for a byte) to extra segment:di and advances di.
- R8: Compare (op code 1) reads the element at source segment:si and then the one at extra segment:di. It sets the zero flag when they are equal and clears it otherwise, writes no memory, and advances both indices.
- R9: Scan (op code 2) compares the accumulator element with the element at extra segment:di. It sets the zero flag on a match and clears it otherwise, and advances di.
- R10: With no prefix (rep code 0), exactly one element is processed and the count is left unchanged.
- R11: Under any prefix (rep codes 1, 2, 3), the count drops by one per element and the operation ends when it reaches zero.
- R12: Repeat-while-equal (rep code 2) also ends a compare or scan when the zero flag comes out 0. Repeat-while-not-equal (rep code 3) also ends it when the zero flag comes out 1. For move, load and store, codes 2 and 3 act as the unconditional repeat.
- R13: A prefixed operation that starts with a count of zero makes no memory access, changes no register, and raises `done` in the cycle after `start`.
- R14: Move, load and store never change the zero flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (idle only) |
| op_sel | input | 3 | 0 move, 1 compare, 2 scan, 3 load, 4 store |
| wide | input | 1 | 0 byte element, 1 word element |
| rep_mode | input | 2 | 0 none, 1 unconditional, 2 while-equal, 3 while-not-equal |
| df_in | input | 1 | Direction flag |
| si_in | input | 16 | Source index at start |
| di_in | input | 16 | Destination index at start |
| cx_in | input | 16 | Count at start |
| acc_in | input | 16 | Accumulator at start |
| src_seg | input | 16 | Source segment base |
| ext_seg | input | 16 | Extra segment base |
| zf_in | input | 1 | Zero flag at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| si_out | output | 16 | Current source index |
| di_out | output | 16 | Current destination index |
| cx_out | output | 16 | Current count |
| acc_out | output | 16 | Current accumulator |
| zf_out | output | 1 | Current zero flag |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after the read request |

## Verification
The bench builds the engine with its default parameters: a two-byte word, 16-bit segments, offsets and count, and a 20-bit address. At these values, a segment and offset of all ones make both the 20-bit truncation and the 16-bit offset wrap of a word's second byte reachable. Counts are drawn small, so the zero-count bypass and every repeat termination path (count exhaustion, equal and not-equal exits) occur often. Bench memory bytes are drawn from a narrow value set so that scan and compare hits are frequent.

// File: rtl/strop_pkg.sv
package strop_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_CMP   = 3'd1,
        OP_SCAN  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } str_op_e;

    typedef enum logic [1:0] {
        RP_NONE = 2'd0,
        RP_ALL  = 2'd1,
        RP_EQ   = 2'd2,
        RP_NE   = 2'd3
    } rep_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC_RQ,
        ST_SRC_CAP,
        ST_DST_RQ,
        ST_DST_CAP,
        ST_WRITE,
        ST_STEP,
        ST_DONE
    } eng_state_e;

    // Entry state of one element, per operation
    function automatic eng_state_e entry_state(input str_op_e op);
        case (op)
            OP_SCAN:  return ST_DST_RQ;
            OP_STORE: return ST_WRITE;
            OP_MOVE,
            OP_CMP,
            OP_LOAD:  return ST_SRC_RQ;
            default:  return ST_STEP;
        endcase
    endfunction

endpackage

// File: rtl/stre_addr_gen.sv
module stre_addr_gen #(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int AW     = 20,
    parameter int BSEL_W = 1
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [BSEL_W-1:0] bidx,
    output logic [AW-1:0]     phys
);
    localparam int SHIFT = AW - SEG_W;

    logic [OFS_W-1:0] eff_ofs;

    // Byte lane offset wraps inside the segment before relocation
    assign eff_ofs = ofs + OFS_W'(bidx);
    assign phys    = AW'({seg, {SHIFT{1'b0}}}) + AW'(eff_ofs);

endmodule

// File: rtl/stre_eval.sv
module stre_eval
    import strop_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CNT_W = 16
) (
    input  str_op_e          op,
    input  rep_e             rep,
    input  logic             wide,
    input  logic [DW-1:0]    sbuf,
    input  logic [DW-1:0]    dbuf,
    input  logic [DW-1:0]    acc,
    input  logic [CNT_W-1:0] cx,
    output logic             zf_new,
    output logic [CNT_W-1:0] cx_next,
    output logic             go_on
);
    localparam int BYTES = DW / 8;

    logic [DW-1:0]    lhs;
    logic [BYTES-1:0] lane_eq;
    logic             is_cond;

    assign lhs     = (op == OP_SCAN) ? acc : sbuf;
    assign is_cond = (op == OP_CMP) || (op == OP_SCAN);

    generate
        for (genvar g = 0; g < BYTES; g++) begin : g_lane
            assign lane_eq[g] = (lhs[8*g +: 8] == dbuf[8*g +: 8]);
        end
    endgenerate

    assign zf_new  = wide ? (&lane_eq) : lane_eq[0];
    assign cx_next = (rep == RP_NONE) ? cx : cx - CNT_W'(1);

    always_comb begin
        go_on = (rep != RP_NONE) && (cx_next != '0);
        if (is_cond && (rep == RP_EQ) && !zf_new) go_on = 1'b0;
        if (is_cond && (rep == RP_NE) &&  zf_new) go_on = 1'b0;
    end

endmodule

// File: rtl/str_op_engine.sv
module str_op_engine
    import strop_pkg::*;
#(
    parameter int DW    = 16,
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int CNT_W = 16,
    parameter int AW    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op_sel,
    input  logic             wide,
    input  logic [1:0]       rep_mode,
    input  logic             df_in,
    input  logic [OFS_W-1:0] si_in,
    input  logic [OFS_W-1:0] di_in,
    input  logic [CNT_W-1:0] cx_in,
    input  logic [DW-1:0]    acc_in,
    input  logic [SEG_W-1:0] src_seg,
    input  logic [SEG_W-1:0] ext_seg,
    input  logic             zf_in,
    output logic             busy,
    output logic             done,
    output logic [OFS_W-1:0] si_out,
    output logic [OFS_W-1:0] di_out,
    output logic [CNT_W-1:0] cx_out,
    output logic [DW-1:0]    acc_out,
    output logic             zf_out,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata
);
    localparam int BYTES  = DW / 8;
    localparam int BSEL_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [BSEL_W-1:0] LAST_W = BSEL_W'(BYTES - 1);

    eng_state_e state_q, state_d;

    str_op_e           op_q;
    rep_e              rep_q;
    logic              wide_q, df_q, zf_q;
    logic [OFS_W-1:0]  si_q, di_q;
    logic [CNT_W-1:0]  cx_q;
    logic [DW-1:0]     acc_q, sbuf_q, dbuf_q;
    logic [SEG_W-1:0]  sseg_q, eseg_q;
    logic [BSEL_W-1:0] bidx_q;

    logic              at_last, zero_skip, uses_src, uses_dst, is_cond;
    logic              zf_new, go_on;
    logic [CNT_W-1:0]  cx_next;
    logic [OFS_W-1:0]  step_v, si_adv, di_adv;
    logic [SEG_W-1:0]  ag_seg;
    logic [OFS_W-1:0]  ag_ofs;
    logic [DW-1:0]     wsrc;

    assign at_last   = (bidx_q == (wide_q ? LAST_W : '0));
    assign zero_skip = (rep_mode != 2'd0) && (cx_in == '0);
    assign uses_src  = (op_q == OP_MOVE) || (op_q == OP_CMP) || (op_q == OP_LOAD);
    assign uses_dst  = (op_q != OP_LOAD);
    assign is_cond   = (op_q == OP_CMP) || (op_q == OP_SCAN);
    assign step_v    = wide_q ? OFS_W'(BYTES) : OFS_W'(1);
    assign si_adv    = df_q ? si_q - step_v : si_q + step_v;
    assign di_adv    = df_q ? di_q - step_v : di_q + step_v;

    stre_eval #(.DW(DW), .CNT_W(CNT_W)) u_eval (
        .op(op_q), .rep(rep_q), .wide(wide_q),
        .sbuf(sbuf_q), .dbuf(dbuf_q), .acc(acc_q), .cx(cx_q),
        .zf_new(zf_new), .cx_next(cx_next), .go_on(go_on)
    );

    stre_addr_gen #(.SEG_W(SEG_W), .OFS_W(OFS_W), .AW(AW), .BSEL_W(BSEL_W)) u_addr (
        .seg(ag_seg), .ofs(ag_ofs), .bidx(bidx_q), .phys(mem_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = zero_skip ? ST_DONE : entry_state(str_op_e'(op_sel));
            ST_SRC_RQ:  state_d = ST_SRC_CAP;
            ST_SRC_CAP: begin
                if (!at_last)               state_d = ST_SRC_RQ;
                else if (op_q == OP_MOVE)   state_d = ST_WRITE;
                else if (op_q == OP_CMP)    state_d = ST_DST_RQ;
                else                        state_d = ST_STEP;
            end
            ST_DST_RQ:  state_d = ST_DST_CAP;
            ST_DST_CAP: state_d = at_last ? ST_STEP : ST_DST_RQ;
            ST_WRITE:   state_d = at_last ? ST_STEP : ST_WRITE;
            ST_STEP:    state_d = go_on ? entry_state(op_q) : ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
        mem_req = (state_q == ST_SRC_RQ) || (state_q == ST_DST_RQ) || (state_q == ST_WRITE);
        mem_we  = (state_q == ST_WRITE);
        ag_seg  = (state_q == ST_SRC_RQ) ? sseg_q : eseg_q;
        ag_ofs  = (state_q == ST_SRC_RQ) ? si_q : di_q;
        wsrc    = (op_q == OP_MOVE) ? sbuf_q : acc_q;
        mem_wdata = wsrc[8*bidx_q +: 8];
    end

    // Register set and element buffers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_MOVE;  rep_q <= RP_NONE;
            wide_q <= 1'b0;   df_q <= 1'b0;   zf_q <= 1'b0;
            si_q <= '0;       di_q <= '0;     cx_q <= '0;
            acc_q <= '0;      sbuf_q <= '0;   dbuf_q <= '0;
            sseg_q <= '0;     eseg_q <= '0;   bidx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    op_q   <= str_op_e'(op_sel);
                    rep_q  <= rep_e'(rep_mode);
                    wide_q <= wide;    df_q <= df_in;   zf_q <= zf_in;
                    si_q   <= si_in;   di_q <= di_in;   cx_q <= cx_in;
                    acc_q  <= acc_in;
                    sseg_q <= src_seg; eseg_q <= ext_seg;
                    bidx_q <= '0;
                end
                ST_SRC_CAP: begin
                    sbuf_q[8*bidx_q +: 8] <= mem_rdata;
                    bidx_q <= at_last ? '0 : bidx_q + BSEL_W'(1);
                end
                ST_DST_CAP: begin
                    dbuf_q[8*bidx_q +: 8] <= mem_rdata;
                    bidx_q <= at_last ? '0 : bidx_q + BSEL_W'(1);
                end
                ST_WRITE: bidx_q <= at_last ? '0 : bidx_q + BSEL_W'(1);
                ST_STEP: begin
                    if (uses_src) si_q <= si_adv;
                    if (uses_dst) di_q <= di_adv;
                    cx_q <= cx_next;
                    if (is_cond) zf_q <= zf_new;
                    if (op_q == OP_LOAD)
                        acc_q <= wide_q ? sbuf_q : {acc_q[DW-1:8], sbuf_q[7:0]};
                end
                default: ;
            endcase
        end
    end

    assign si_out  = si_q;
    assign di_out  = di_q;
    assign cx_out  = cx_q;
    assign acc_out = acc_q;
    assign zf_out  = zf_q;

    // Assertions
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r13_zero_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && rep_mode != 2'd0 && cx_in == '0) |=> (done && cx_out == $past(cx_in)));

    a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && rep_q == RP_NONE) |-> $stable(cx_out));

    a_r14_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !is_cond) |-> $stable(zf_out));

    a_r8_no_write_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (op_q == OP_MOVE || op_q == OP_STORE));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

// File: tb/tb_str_op_engine.sv
`timescale 1ns/1ps
module tb_str_op_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        wide = 1'b0;
    logic [1:0]  rep_mode = '0;
    logic        df_in = 1'b0;
    logic [15:0] si_in = '0, di_in = '0, cx_in = '0, acc_in = '0;
    logic [15:0] src_seg = '0, ext_seg = '0;
    logic        zf_in = 1'b0;
    logic        busy, done, zf_out, mem_req, mem_we;
    logic [15:0] si_out, di_out, cx_out, acc_out;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int dut_req = 0;

    logic [7:0]  mem  [logic [19:0]];
    logic [7:0]  rmem [logic [19:0]];
    logic [27:0] dut_wr[$];
    logic [27:0] exp_wr[$];

    always #5 clk = ~clk;

    str_op_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .wide(wide),
        .rep_mode(rep_mode), .df_in(df_in), .si_in(si_in), .di_in(di_in),
        .cx_in(cx_in), .acc_in(acc_in), .src_seg(src_seg), .ext_seg(ext_seg),
        .zf_in(zf_in), .busy(busy), .done(done), .si_out(si_out), .di_out(di_out),
        .cx_out(cx_out), .acc_out(acc_out), .zf_out(zf_out), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] init_b(input logic [19:0] a);
        int x = int'(a);
        return 8'((x * 37 ^ (x >> 7)) & 15);
    endfunction

    function automatic logic [7:0] dut_rd(input logic [19:0] a);
        return mem.exists(a) ? mem[a] : init_b(a);
    endfunction

    function automatic logic [7:0] ref_rd(input logic [19:0] a);
        return rmem.exists(a) ? rmem[a] : init_b(a);
    endfunction

    function automatic logic [19:0] pa(input logic [15:0] seg, input logic [15:0] ofs);
        return {seg, 4'b0} + {4'b0, ofs};
    endfunction

    // Synchronous byte memory, read data one cycle after request
    always @(posedge clk) begin
        if (mem_req) begin
            dut_req++;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                dut_wr.push_back({mem_addr, mem_wdata});
            end else begin
                mem_rdata <= dut_rd(mem_addr);
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic poke(input logic [19:0] a, input logic [7:0] d);
        mem[a] = d;
        rmem[a] = d;
    endtask

    // Reference model computed from the requirements
    task automatic model(input int op, input bit w, input int rep, input bit df,
                         input logic [15:0] ss, input logic [15:0] es,
                         inout logic [15:0] si, inout logic [15:0] di, inout logic [15:0] cx,
                         inout logic [15:0] acc, inout logic zf, output int nreq);
        int n = w ? 2 : 1;
        logic [15:0] a, b, st;
        bit cnd;
        nreq = 0;
        st = w ? 16'd2 : 16'd1;
        cnd = (op == 1) || (op == 2);
        if (rep != 0 && cx == 0) return;
        forever begin
            a = '0; b = '0;
            if (op == 0 || op == 1 || op == 3)
                for (int k = 0; k < n; k++) begin a[8*k +: 8] = ref_rd(pa(ss, si + 16'(k))); nreq++; end
            if (op == 1 || op == 2)
                for (int k = 0; k < n; k++) begin b[8*k +: 8] = ref_rd(pa(es, di + 16'(k))); nreq++; end
            if (op == 0 || op == 4)
                for (int k = 0; k < n; k++) begin
                    logic [19:0] ad = pa(es, di + 16'(k));
                    logic [7:0]  v  = (op == 0) ? a[8*k +: 8] : acc[8*k +: 8];
                    rmem[ad] = v;
                    exp_wr.push_back({ad, v});
                    nreq++;
                end
            if (op == 1) zf = w ? (a == b) : (a[7:0] == b[7:0]);
            if (op == 2) zf = w ? (acc == b) : (acc[7:0] == b[7:0]);
            if (op == 3) acc = w ? a : {acc[15:8], a[7:0]};
            if (op == 0 || op == 1 || op == 3) si = df ? si - st : si + st;
            if (op != 3) di = df ? di - st : di + st;
            if (rep == 0) break;
            cx = cx - 16'd1;
            if (cx == 0) break;
            if (cnd && rep == 2 && !zf) break;
            if (cnd && rep == 3 && zf) break;
        end
    endtask

    task automatic run(input int op, input bit w, input int rep, input bit df,
                       input logic [15:0] si, input logic [15:0] di, input logic [15:0] cx,
                       input logic [15:0] acc, input logic [15:0] ss, input logic [15:0] es,
                       input logic zf, input bit zero_case);
        logic [15:0] esi = si, edi = di, ecx = cx, eacc = acc;
        logic ezf = zf;
        int nreq, cyc;
        bit first_done;
        string rq;
        case (op)
            0: rq = "R5"; 1: rq = "R8"; 2: rq = "R9"; 3: rq = "R6"; default: rq = "R7";
        endcase
        exp_wr.delete();
        model(op, w, rep, df, ss, es, esi, edi, ecx, eacc, ezf, nreq);
        @(negedge clk);
        dut_wr.delete();
        dut_req = 0;
        op_sel = 3'(op); wide = w; rep_mode = 2'(rep); df_in = df;
        si_in = si; di_in = di; cx_in = cx; acc_in = acc;
        src_seg = ss; ext_seg = es; zf_in = zf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first_done = done;
        cyc = 0;
        // Watchdog for a hung operation
        while (!done && cyc < 400) begin @(negedge clk); cyc++; end
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R1 watchdog: actual busy %0d expected done", busy);
            return;
        end
        if (zero_case) chk("R13", "done next cycle", 32'(first_done), 32'd1);
        chk("R4", "si", 32'(si_out), 32'(esi));
        chk("R4", "di", 32'(di_out), 32'(edi));
        chk(rep == 0 ? "R10" : "R11", "count", 32'(cx_out), 32'(ecx));
        chk(rq, "acc", 32'(acc_out), 32'(eacc));
        chk((op == 1 || op == 2) ? rq : "R14", "zf", 32'(zf_out), 32'(ezf));
        chk(rep >= 2 ? "R12" : rq, "access count", 32'(dut_req), 32'(nreq));
        chk("R3", "write count", 32'(dut_wr.size()), 32'(exp_wr.size()));
        for (int i = 0; i < dut_wr.size() && i < exp_wr.size(); i++)
            chk("R2", "write addr/data", 32'(dut_wr[i]), 32'(exp_wr[i]));
        @(negedge clk);
        chk("R1", "done one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1", "reset busy", 32'(busy), 32'd0);
        chk("R1", "reset done", 32'(done), 32'd0);
        chk("R1", "reset mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R10: single byte move, increment
        run(0, 0, 0, 0, 16'h0010, 16'h0200, 16'd9, 16'h0, 16'h1000, 16'h2000, 0, 0);
        // R4 R11 R3: repeated word move, decrement
        run(0, 1, 1, 1, 16'h0040, 16'h0080, 16'd3, 16'h0, 16'h0100, 16'h0300, 1, 0);
        // R13: zero count under prefix
        run(0, 1, 1, 0, 16'h0001, 16'h0002, 16'd0, 16'h1234, 16'h0, 16'h0, 1, 1);
        run(2, 0, 3, 0, 16'h0001, 16'h0002, 16'd0, 16'h0005, 16'h0, 16'h0, 0, 1);
        // R8 R12: repeat-while-equal compare, mismatch on second element
        poke(pa(16'h0500, 16'h0000), 8'hA1); poke(pa(16'h0600, 16'h0000), 8'hA1);
        poke(pa(16'h0500, 16'h0001), 8'hB2); poke(pa(16'h0600, 16'h0001), 8'hC3);
        run(1, 0, 2, 0, 16'h0000, 16'h0000, 16'd5, 16'h0, 16'h0500, 16'h0600, 0, 0);
        // R9 R12: repeat-while-not-equal scan, match on third word
        poke(pa(16'h0700, 16'h0010), 8'h11); poke(pa(16'h0700, 16'h0011), 8'h22);
        poke(pa(16'h0700, 16'h000E), 8'h33); poke(pa(16'h0700, 16'h000F), 8'h44);
        poke(pa(16'h0700, 16'h000C), 8'h77); poke(pa(16'h0700, 16'h000D), 8'h66);
        run(2, 1, 3, 1, 16'h0, 16'h0010, 16'd6, 16'h6677, 16'h0, 16'h0700, 0, 0);
        // R6: byte load keeps upper accumulator byte
        poke(pa(16'h0800, 16'h0003), 8'h5C);
        run(3, 0, 0, 0, 16'h0003, 16'h0, 16'd2, 16'hBEEF, 16'h0800, 16'h0, 1, 0);
        // R7 R2 R3: word store at segment/offset wrap
        run(4, 1, 0, 0, 16'h0, 16'hFFFF, 16'd1, 16'hCAFE, 16'h0, 16'hFFFF, 0, 0);
        // R12: conditional prefix on load behaves as plain repeat
        run(3, 1, 2, 0, 16'h0020, 16'h0, 16'd4, 16'h0, 16'h0900, 16'h0, 0, 0);
        // R7 R11: repeated byte store, decrement
        run(4, 0, 1, 1, 16'h0, 16'h0003, 16'd4, 16'h00E7, 16'h0, 16'h0A00, 1, 0);

        // Constrained random mix
        for (int t = 0; t < 300; t++) begin
            int op = $urandom_range(0, 4);
            bit w = 1'($urandom_range(0, 1));
            int rep = $urandom_range(0, 3);
            bit df = 1'($urandom_range(0, 1));
            logic [15:0] si = 16'($urandom), di = 16'($urandom);
            logic [15:0] ss = 16'($urandom), es = 16'($urandom);
            logic [15:0] acc = 16'($urandom);
            logic [15:0] cx = 16'($urandom_range(0, 6));
            if (op == 2 && $urandom_range(0, 1) == 1) acc = acc & 16'h0F0F;
            if (op == 1 && $urandom_range(0, 3) == 0) begin es = ss; di = si; end
            run(op, w, rep, df, si, di, cx, acc, ss, es, 1'($urandom_range(0, 1)), cx == 0 && rep != 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule